// File: doc/BRIEF.md
# Banked Interrupt Controller with CPU Routing

This block gathers up to 32 interrupt sources, conditions each one by its own trigger type and presents the result to two processor interrupt lines. Every source can be set up for rising-edge, falling-edge, any-edge, active-high level or active-low level detection. Edge events are held in a sticky latch until software clears them. Level sources follow the live input.

Software reaches the block through a small word-addressed register port. Writes land on the next clock edge. Read data is combinational from the address. Enables and software-raised requests each have a plain form, a set form and a clear form. The set and clear forms come in two kinds: one takes a bit mask and the other takes a source number. Each source has two routing bits, one for each processor line. A status word shows the enabled active sources. A pending-number register names the lowest of them, so a handler can take the requests in ascending order.

Top module: `irqbank_top`

## Requirements
- R1: After reset, the following hold:
  - Enable, soft-request, sense and any-edge words read 0.
  - The polarity word and the CPU0 routing word read all ones.
  - The CPU1 routing word reads 0.
  - Status and the pending number read 0.
  - Both processor lines are low.
- R2: Rising-edge mode is sense bit 0, any-edge bit 0 and polarity bit 1. In this mode a 0-to-1 input change latches an event. The event stays after the input returns to 0.
- R3: Falling-edge mode is sense 0, any-edge 0 and polarity 0. In this mode a 1-to-0 change latches an event and a 0-to-1 change does not.
- R4: Any-edge mode is sense 0 and any-edge 1. In this mode both input transitions latch an event, whatever the polarity bit holds.
- R5: Level mode is sense 1. The source is active while the synchronised input equals the polarity bit (1 = high, 0 = low). It drops as soon as the input leaves that value, and nothing is latched.
- R6: Mask set (0x03) and mask clear (0x04) change only the enable bits that are one in the written data. A zero mask leaves enables unchanged. Status (0x00) is the raw active word (0x01) ANDed with the enables.
- R7: Number set (0x05) and number clear (0x06) change only the enable bit named by write data bits [4:0].
- R8: Edge clear by mask (0x07) or by number (0x08) drops latched edge events. Writing all ones drops every latched event. An edge arriving in the same cycle as the clear is kept.
- R9: A software request counts as an active source in any trigger mode and is gated by the enable. The request is set by mask (0x0A) or by number (0x0C) and cleared by mask (0x0B) or by number (0x0D). The whole word is at 0x09.
- R10: A processor line goes high one clock after status has an enabled source whose routing bit for that line is set. It goes low one clock after no such source remains. Line 0 uses the routing word at 0x11 and line 1 the word at 0x12.
- R11: The pending number (0x13) is the lowest set bit position of status, or 0 when status is 0. Status bit 0 tells source 0 apart from no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Asynchronous interrupt source inputs |
| addr | input | 5 | Register word address for read and write |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | N_SRC | Write data, mask or source number in bits [4:0] |
| rd_data | output | N_SRC | Combinational read data for `addr` |
| cpu0_irq | output | 1 | Registered interrupt line to processor 0 |
| cpu1_irq | output | 1 | Registered interrupt line to processor 1 |

## Verification
The hardest case to reach is telling a latched edge apart from a level that is still present. Doing so needs an input pulse that has already ended, followed by a readback that still shows the event. The stimulus pulses a source and then releases it before reading status. It then clears the latch, and for the any-edge source it produces the second transition. Pending number 0 is also hard, because from the ports it looks the same as an idle controller. The bench raises a software request on source 0 while source 31 is already pending, and checks both the number and status bit 0.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

   localparam int unsigned REG_AW = 5;

   typedef enum logic [REG_AW-1:0] {
      RA_STATUS      = 5'h00,
      RA_RAW         = 5'h01,
      RA_ENABLE      = 5'h02,
      RA_EN_SET      = 5'h03,
      RA_EN_CLR      = 5'h04,
      RA_EN_SET_IX   = 5'h05,
      RA_EN_CLR_IX   = 5'h06,
      RA_EDGE_CLR    = 5'h07,
      RA_EDGE_CLR_IX = 5'h08,
      RA_SOFT        = 5'h09,
      RA_SOFT_SET    = 5'h0A,
      RA_SOFT_CLR    = 5'h0B,
      RA_SOFT_SET_IX = 5'h0C,
      RA_SOFT_CLR_IX = 5'h0D,
      RA_SENSE       = 5'h0E,
      RA_ANYEDGE     = 5'h0F,
      RA_POL         = 5'h10,
      RA_ROUTE0      = 5'h11,
      RA_ROUTE1      = 5'h12,
      RA_PEND        = 5'h13
   } reg_addr_e;

   // Edge event for one source: any-edge overrides polarity.
   function automatic logic edge_hit(input logic any_edge, input logic pol,
                                     input logic cur, input logic prev);
      if (any_edge) return cur ^ prev;
      if (pol)      return cur & ~prev;
      return ~cur & prev;
   endfunction

endpackage

// File: rtl/irqbank_sync.sv
module irqbank_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irqbank_detect.sv
module irqbank_detect
   import irqbank_pkg::*;
#(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lvl,
   input  logic [N_SRC-1:0] sense,
   input  logic [N_SRC-1:0] any_edge,
   input  logic [N_SRC-1:0] pol,
   input  logic [N_SRC-1:0] clr_mask,
   output logic [N_SRC-1:0] hw_active
);

   logic [N_SRC-1:0] prev_q;
   logic [N_SRC-1:0] latch_q;
   logic [N_SRC-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         assign hit[i]       = !sense[i] && edge_hit(any_edge[i], pol[i], lvl[i], prev_q[i]);
         assign hw_active[i] = sense[i] ? ~(lvl[i] ^ pol[i]) : latch_q[i];
      end
   endgenerate

   // A new event in the same cycle as a clear survives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q & ~clr_mask) | hit;
   end

endmodule

// File: rtl/irqbank_prio.sv
module irqbank_prio #(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned IDX_W = 5,
   parameter bit          TREE  = 1'b1
) (
   input  logic [N_SRC-1:0] req,
   output logic [IDX_W-1:0] idx
);

   localparam int unsigned P = 1 << IDX_W;

   generate
      if (TREE) begin : g_tree
         logic             vld [IDX_W+1][P];
         logic [IDX_W-1:0] ixa [IDX_W+1][P];
         always_comb begin
            for (int k = 0; k <= IDX_W; k++) begin
               for (int j = 0; j < P; j++) begin
                  vld[k][j] = 1'b0;
                  ixa[k][j] = '0;
               end
            end
            for (int j = 0; j < N_SRC; j++) vld[0][j] = req[j];
            for (int k = 0; k < IDX_W; k++) begin
               for (int j = 0; j < (P >> (k + 1)); j++) begin
                  if (vld[k][2*j]) begin
                     vld[k+1][j] = 1'b1;
                     ixa[k+1][j] = ixa[k][2*j];
                  end else begin
                     vld[k+1][j] = vld[k][2*j+1];
                     ixa[k+1][j] = ixa[k][2*j+1] | (IDX_W'(1) << k);
                  end
               end
            end
            idx = vld[IDX_W][0] ? ixa[IDX_W][0] : '0;
         end
      end else begin : g_linear
         always_comb begin
            idx = '0;
            for (int i = N_SRC - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
   import irqbank_pkg::*;
#(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] addr,
   input  logic              wr_en,
   input  logic [N_SRC-1:0]  wr_data,
   output logic [N_SRC-1:0]  rd_data,
   input  logic [N_SRC-1:0]  status,
   input  logic [N_SRC-1:0]  raw,
   input  logic [IDX_W-1:0]  pend_idx,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  soft_q,
   output logic [N_SRC-1:0]  sense_q,
   output logic [N_SRC-1:0]  anyedge_q,
   output logic [N_SRC-1:0]  pol_q,
   output logic [N_SRC-1:0]  route0_q,
   output logic [N_SRC-1:0]  route1_q,
   output logic [N_SRC-1:0]  edge_clr
);

   logic [IDX_W-1:0] wix;
   logic [N_SRC-1:0] ixm;

   assign wix = wr_data[IDX_W-1:0];
   assign ixm = (32'(wix) < N_SRC) ? (N_SRC'(1) << wix) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         soft_q    <= '0;
         sense_q   <= '0;
         anyedge_q <= '0;
         pol_q     <= '1;
         route0_q  <= '1;
         route1_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            RA_ENABLE:      en_q      <= wr_data;
            RA_EN_SET:      en_q      <= en_q | wr_data;
            RA_EN_CLR:      en_q      <= en_q & ~wr_data;
            RA_EN_SET_IX:   en_q      <= en_q | ixm;
            RA_EN_CLR_IX:   en_q      <= en_q & ~ixm;
            RA_SOFT:        soft_q    <= wr_data;
            RA_SOFT_SET:    soft_q    <= soft_q | wr_data;
            RA_SOFT_CLR:    soft_q    <= soft_q & ~wr_data;
            RA_SOFT_SET_IX: soft_q    <= soft_q | ixm;
            RA_SOFT_CLR_IX: soft_q    <= soft_q & ~ixm;
            RA_SENSE:       sense_q   <= wr_data;
            RA_ANYEDGE:     anyedge_q <= wr_data;
            RA_POL:         pol_q     <= wr_data;
            RA_ROUTE0:      route0_q  <= wr_data;
            RA_ROUTE1:      route1_q  <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      edge_clr = '0;
      if (wr_en && addr == RA_EDGE_CLR)    edge_clr = wr_data;
      if (wr_en && addr == RA_EDGE_CLR_IX) edge_clr = ixm;
   end

   always_comb begin
      case (addr)
         RA_STATUS:  rd_data = status;
         RA_RAW:     rd_data = raw;
         RA_ENABLE:  rd_data = en_q;
         RA_SOFT:    rd_data = soft_q;
         RA_SENSE:   rd_data = sense_q;
         RA_ANYEDGE: rd_data = anyedge_q;
         RA_POL:     rd_data = pol_q;
         RA_ROUTE0:  rd_data = route0_q;
         RA_ROUTE1:  rd_data = route1_q;
         RA_PEND:    rd_data = N_SRC'(pend_idx);
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
   import irqbank_pkg::*;
#(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PRIO_TREE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_in,
   input  logic [REG_AW-1:0] addr,
   input  logic              wr_en,
   input  logic [N_SRC-1:0]  wr_data,
   output logic [N_SRC-1:0]  rd_data,
   output logic              cpu0_irq,
   output logic              cpu1_irq
);

   localparam int unsigned IDX_W = $clog2(N_SRC);

   generate
      if (N_SRC < 2 || N_SRC > 32) begin : g_bad_nsrc
         $error("irqbank_top: N_SRC must lie in 2..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irqbank_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [N_SRC-1:0] lvl;
   logic [N_SRC-1:0] hw_active;
   logic [N_SRC-1:0] raw;
   logic [N_SRC-1:0] status;
   logic [IDX_W-1:0] pend_idx;
   logic [N_SRC-1:0] en_q, soft_q, sense_q, anyedge_q, pol_q;
   logic [N_SRC-1:0] route0_q, route1_q, edge_clr;

   irqbank_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_in), .q(lvl)
   );

   irqbank_detect #(.N_SRC(N_SRC)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .sense(sense_q),
      .any_edge(anyedge_q), .pol(pol_q), .clr_mask(edge_clr),
      .hw_active(hw_active)
   );

   assign raw    = hw_active | soft_q;
   assign status = raw & en_q;

   irqbank_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W), .TREE(PRIO_TREE)) u_prio (
      .req(status), .idx(pend_idx)
   );

   irqbank_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .status(status), .raw(raw),
      .pend_idx(pend_idx), .en_q(en_q), .soft_q(soft_q), .sense_q(sense_q),
      .anyedge_q(anyedge_q), .pol_q(pol_q), .route0_q(route0_q),
      .route1_q(route1_q), .edge_clr(edge_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu0_irq <= 1'b0;
         cpu1_irq <= 1'b0;
      end else begin
         cpu0_irq <= |(status & route0_q);
         cpu1_irq <= |(status & route1_q);
      end
   end

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] status,
   input logic [N_SRC-1:0] route0_q,
   input logic [N_SRC-1:0] route1_q,
   input logic [IDX_W-1:0] pend_idx,
   input logic             cpu0_irq,
   input logic             cpu1_irq
);

   a_r10_cpu0_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & route0_q)) |=> cpu0_irq);
   a_r10_cpu0_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & route0_q)) |=> !cpu0_irq);
   a_r10_cpu1_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & route1_q)) |=> cpu1_irq);
   a_r10_cpu1_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & route1_q)) |=> !cpu1_irq);
   a_r11_pend_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (status != '0) |-> (status[pend_idx] &&
         ((status & ((N_SRC'(1) << pend_idx) - N_SRC'(1))) == '0)));
   a_r11_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> (pend_idx == '0));

endmodule

bind irqbank_top irqbank_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .status(status), .route0_q(route0_q),
   .route1_q(route1_q), .pend_idx(pend_idx), .cpu0_irq(cpu0_irq),
   .cpu1_irq(cpu1_irq)
);

// File: tb/irqbank_top_tb.sv
`timescale 1ns/1ps
module irqbank_top_tb;
   import irqbank_pkg::*;

   localparam int unsigned N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_in = '0;
   logic [4:0]    addr = '0;
   logic          wr_en = 1'b0;
   logic [N-1:0]  wr_data = '0;
   logic [N-1:0]  rd_data;
   logic          cpu0_irq, cpu1_irq;

   typedef struct {
      bit         is_cpu;
      logic [4:0] a;
      logic [N-1:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   irqbank_top #(.N_SRC(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .cpu0_irq(cpu0_irq),
      .cpu1_irq(cpu1_irq)
   );

   task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_rd(input logic [4:0] a, input logic [N-1:0] e, input string t);
      item_t it;
      @(negedge clk);
      addr = a;
      it.is_cpu = 1'b0; it.a = a; it.exp = e; it.tag = t;
      q.push_back(it);
   endtask

   task automatic chk_cpu(input logic [1:0] e, input string t);
      item_t it;
      @(negedge clk);
      it.is_cpu = 1'b1; it.a = '0; it.exp = N'(e); it.tag = t;
      q.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: compares each queued expectation just after the negedge it was issued on.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [N-1:0] act;
            it = q.pop_front();
            act = it.is_cpu ? N'({cpu1_irq, cpu0_irq}) : rd_data;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: addr %0h got %h expected %h", it.tag, it.a, act, it.exp);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk_rd(RA_STATUS,  32'h0,         "R1 status");
      chk_rd(RA_ENABLE,  32'h0,         "R1 enable");
      chk_rd(RA_ROUTE0,  32'hFFFF_FFFF, "R1 route0");
      chk_rd(RA_ROUTE1,  32'h0,         "R1 route1");
      chk_rd(RA_POL,     32'hFFFF_FFFF, "R1 polarity");
      chk_rd(RA_SENSE,   32'h0,         "R1 sense");
      chk_rd(RA_PEND,    32'h0,         "R1 pending");
      chk_cpu(2'b00,                    "R1 cpu lines");

      // R2 rising edge, latched after release
      wr(RA_EN_SET, 32'h0000_0005);
      chk_rd(RA_ENABLE, 32'h5, "R6 mask set");
      src_in[2] = 1'b1; idle(5);
      chk_rd(RA_STATUS, 32'h4, "R2 rising latched");
      src_in[2] = 1'b0; idle(5);
      chk_rd(RA_STATUS, 32'h4, "R2 held after release");
      chk_rd(RA_PEND,   32'h2, "R11 lowest index");
      chk_cpu(2'b01,           "R10 route to cpu0");

      // R8 clear by number
      wr(RA_EDGE_CLR_IX, 32'd2);
      chk_rd(RA_STATUS, 32'h0, "R8 clear by number");
      chk_cpu(2'b00,           "R10 line drops");

      // R3 falling edge
      wr(RA_POL, 32'hFFFF_FFF7);
      wr(RA_EN_SET_IX, 32'd3);
      chk_rd(RA_ENABLE, 32'hD, "R7 number set");
      src_in[3] = 1'b1; idle(5);
      chk_rd(RA_STATUS, 32'h0, "R3 rising ignored");
      src_in[3] = 1'b0; idle(5);
      chk_rd(RA_STATUS, 32'h8, "R3 falling latched");

      // R4 any edge
      wr(RA_ANYEDGE, 32'h10);
      wr(RA_EN_SET,  32'h10);
      src_in[4] = 1'b1; idle(5);
      chk_rd(RA_STATUS, 32'h18, "R4 rise latched");
      wr(RA_EDGE_CLR, 32'h10);
      chk_rd(RA_STATUS, 32'h08, "R8 clear by mask");
      src_in[4] = 1'b0; idle(5);
      chk_rd(RA_STATUS, 32'h18, "R4 fall latched");
      wr(RA_EDGE_CLR, 32'hFFFF_FFFF);
      chk_rd(RA_STATUS, 32'h0,  "R8 clear all");

      // R5 level modes
      wr(RA_SENSE,  32'h20);
      wr(RA_EN_SET, 32'h20);
      src_in[5] = 1'b1; idle(4);
      chk_rd(RA_STATUS, 32'h20, "R5 high level active");
      src_in[5] = 1'b0; idle(4);
      chk_rd(RA_STATUS, 32'h0,  "R5 high level not latched");
      wr(RA_POL, 32'hFFFF_FFD7);
      idle(2);
      chk_rd(RA_STATUS, 32'h20, "R5 low level active");
      src_in[5] = 1'b1; idle(4);
      chk_rd(RA_STATUS, 32'h0,  "R5 low level released");
      src_in[5] = 1'b0; idle(4);

      // R6 mask clear and zero mask
      wr(RA_EN_CLR, 32'h20);
      chk_rd(RA_ENABLE, 32'h1D, "R6 mask clear");
      wr(RA_EN_SET, 32'h0);
      chk_rd(RA_ENABLE, 32'h1D, "R6 zero mask no effect");
      chk_rd(RA_STATUS, 32'h0,  "R6 disabled source masked");
      chk_rd(RA_RAW,    32'h20, "R6 raw shows source");

      // R7 clear by number
      wr(RA_EN_CLR_IX, 32'd4);
      chk_rd(RA_ENABLE, 32'hD, "R7 number clear");

      // R9 soft requests, R10 routing, R11 source 0
      wr(RA_SOFT_SET, 32'h8000_0000);
      chk_rd(RA_STATUS, 32'h0,         "R9 soft gated by enable");
      chk_rd(RA_SOFT,   32'h8000_0000, "R9 soft readback");
      wr(RA_EN_SET_IX, 32'd31);
      chk_rd(RA_STATUS, 32'h8000_0000, "R9 soft active");
      chk_rd(RA_PEND,   32'd31,        "R11 top source");
      wr(RA_ROUTE0, 32'h7FFF_FFFF);
      wr(RA_ROUTE1, 32'h8000_0000);
      idle(1);
      chk_cpu(2'b10,                   "R10 route to cpu1");
      wr(RA_SOFT_SET_IX, 32'd0);
      chk_rd(RA_STATUS, 32'h8000_0001, "R9 soft by number");
      chk_rd(RA_PEND,   32'd0,         "R11 source 0 pending");
      chk_cpu(2'b11,                   "R10 both lines");
      wr(RA_SOFT_CLR, 32'h1);
      wr(RA_SOFT_CLR_IX, 32'd31);
      chk_rd(RA_STATUS, 32'h0,         "R9 soft cleared");
      chk_rd(RA_PEND,   32'd0,         "R11 idle reads zero");
      chk_cpu(2'b00,                   "R10 lines idle");

      idle(3);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule